// File: doc/BRIEF.md
# Backup Battery Supervision Sequencer

This block runs the digital side of battery supervision for a position sensor that keeps tracking on a backup cell. It sends a one-cycle enable pulse to a bank of external comparators once per sampling period, then reads their digitised results a fixed number of slow-clock cycles later. The comparators report three battery levels: brown-out, error threshold and warning threshold. A 3-bit rate field sets the period, and each code step is about four times faster than the one before. A 2-bit mode field turns supervision off or on.

The results feed two sticky flags: one for battery error, set by the brown-out or error comparator, and one for battery warning. These flags drive active-low status pins. A status-clear strobe only arms a clear. The next sample then reloads both flags from the comparator values at that sample, so a condition that is still present stays flagged. The block also turns the threshold selection field into the code that goes to the analog threshold ladder. Reserved codes are replaced by the highest threshold pair and a configuration error is raised. Finally, it registers the supply choice (main supply or battery) from a main-supply-good input that has already been debounced.

Top module: `batMonSeq`

## Requirements
- R1: The interval between enable pulses, in slow-clock cycles, is max(BASE_TICKS / 4^code, SETTLE+1) for rate codes 0 to 6. Rate code 7 gives back-to-back sampling with interval SETTLE+1. A new rate takes effect at the next pulse.
- R2: When the mode field is 00, no enable pulse is issued and both flags keep their values. Any other mode value enables supervision.
- R3: Each enable pulse is high for exactly one cycle. The first pulse comes on the first clock edge at which supervision is enabled, whether that edge ends reset or follows a change of the mode field away from 00.
- R4: The comparator inputs are captured only on the clock edge that comes exactly SETTLE cycles after the edge that raised the enable pulse. Values present on any other edge are ignored.
- R5: A captured error-level or brown-out-level comparator bit sets the error flag. A captured warning-level bit sets the warning flag. Output nErr is 0 while the error flag is set, and nWrn is 0 while the warning flag is set.
- R6: Once set, a flag stays set until a status-clear strobe has been seen. The first sample after that strobe replaces both flags with the comparator values captured at that sample.
- R7: thrCode follows thrSel one cycle later for codes 0 to 4. Codes 5 to 7 give thrCode = 0 (the highest threshold pair) and cfgErr = 1. Otherwise cfgErr = 0.
- R8: onBattery is the inverse of mainGood, registered once. It resets to 1.
- R9: During reset, cmpEnable = 0, nErr = 1, nWrn = 1 and cfgErr = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow tick clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rateSel | input | 3 | Sampling period code |
| monMode | input | 2 | Supervision mode, 00 = off |
| thrSel | input | 3 | Threshold pair selection |
| statusClr | input | 1 | One-cycle strobe that arms a flag clear |
| mainGood | input | 1 | Debounced main supply above threshold |
| cmpBrownOut | input | 1 | Battery below brown-out level |
| cmpError | input | 1 | Battery below error level |
| cmpWarn | input | 1 | Battery below warning level |
| cmpEnable | output | 1 | Comparator enable pulse |
| thrCode | output | 3 | Sanitised threshold code to analog |
| cfgErr | output | 1 | Reserved threshold code in use |
| onBattery | output | 1 | Running from battery supply |
| nErr | output | 1 | Battery error status, active low |
| nWrn | output | 1 | Battery warning status, active low |

## Verification
If the period counter or the settle counter holds a wrong value, pulse spacing is off or captures land on the wrong edge. The pulse spacing shows up on the next pulse, because the bench measures every interval. The capture edge is exposed by one-cycle comparator windows placed one cycle early and exactly on time. If the clear-pending state is lost or stuck, a flag stays asserted or drops while its condition is still present. This shows up at nErr or nWrn within one sampling period after the strobe.

// File: rtl/batMonPkg.sv
package batMonPkg;
  localparam int RATE_W = 3;
  localparam int MODE_W = 2;
  localparam int THR_W  = 3;
  localparam logic [THR_W-1:0] THR_LAST = 3'd4;

  typedef struct packed {
    logic sample;
    logic clear;
  } monStb_t;
endpackage

// File: rtl/batMonCtrl.sv
module batMonCtrl
  import batMonPkg::*;
#(
  parameter int BASE_TICKS = 65536,
  parameter int SETTLE     = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [RATE_W-1:0] rateSel,
  input  logic [MODE_W-1:0] monMode,
  input  logic              statusClr,
  input  logic              mainGood,
  output logic              cmpEnable,
  output logic              onBattery,
  output monStb_t           stb
);
  localparam int CNT_W   = $clog2(BASE_TICKS + 1);
  localparam int SET_W   = $clog2(SETTLE + 1) + 1;
  localparam int NCODES  = 1 << RATE_W;
  localparam int MIN_PER = SETTLE + 1;

  logic [CNT_W-1:0] periodTab [NCODES];
  logic [CNT_W-1:0] tickCnt;
  logic [SET_W-1:0] settleCnt;
  logic             pulseQ;
  logic             clrPend;
  logic             onBatQ;
  logic             active;
  logic             sampleNow;

  // One period per rate code: four times shorter per step, never shorter than the settle window
  for (genvar g = 0; g < NCODES; g++) begin : g_period
    localparam int RAW = (g == NCODES - 1) ? MIN_PER : (BASE_TICKS >> (2 * g));
    localparam int PER = (RAW < MIN_PER) ? MIN_PER : RAW;
    assign periodTab[g] = CNT_W'(PER);
  end

  assign active    = |monMode;
  assign sampleNow = active && (settleCnt == SET_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt   <= '0;
      settleCnt <= '0;
      pulseQ    <= 1'b0;
    end else if (!active) begin
      tickCnt   <= '0;
      settleCnt <= '0;
      pulseQ    <= 1'b0;
    end else begin
      pulseQ <= (tickCnt == '0);
      if (tickCnt == '0) begin
        tickCnt   <= periodTab[rateSel] - CNT_W'(1);
        settleCnt <= SET_W'(SETTLE);
      end else begin
        tickCnt <= tickCnt - CNT_W'(1);
        if (settleCnt != '0) settleCnt <= settleCnt - SET_W'(1);
      end
    end
  end

  // A clear request waits for the next capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clrPend <= 1'b0;
    else if (statusClr) clrPend <= 1'b1;
    else if (sampleNow) clrPend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) onBatQ <= 1'b1;
    else onBatQ <= !mainGood;
  end

  assign stb.sample = sampleNow;
  assign stb.clear  = sampleNow && clrPend;
  assign cmpEnable  = pulseQ;
  assign onBattery  = onBatQ;
endmodule

// File: rtl/batMonDatapath.sv
module batMonDatapath
  import batMonPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  monStb_t          stb,
  input  logic [THR_W-1:0] thrSel,
  input  logic             cmpBrownOut,
  input  logic             cmpError,
  input  logic             cmpWarn,
  output logic [THR_W-1:0] thrCode,
  output logic             cfgErr,
  output logic             nErr,
  output logic             nWrn
);
  logic             errQ, wrnQ;
  logic             errHit, wrnHit;
  logic             thrBad;
  logic [THR_W-1:0] thrQ;
  logic             cfgQ;

  assign errHit = cmpError | cmpBrownOut;
  assign wrnHit = cmpWarn;
  assign thrBad = thrSel > THR_LAST;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errQ <= 1'b0;
      wrnQ <= 1'b0;
    end else if (stb.clear) begin
      errQ <= errHit;
      wrnQ <= wrnHit;
    end else if (stb.sample) begin
      errQ <= errQ | errHit;
      wrnQ <= wrnQ | wrnHit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thrQ <= '0;
      cfgQ <= 1'b0;
    end else begin
      thrQ <= thrBad ? '0 : thrSel;
      cfgQ <= thrBad;
    end
  end

  assign thrCode = thrQ;
  assign cfgErr  = cfgQ;
  assign nErr    = !errQ;
  assign nWrn    = !wrnQ;
endmodule

// File: rtl/batMonSeq.sv
module batMonSeq
  import batMonPkg::*;
#(
  parameter int BASE_TICKS = 65536,
  parameter int SETTLE     = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  rateSel,
  input  logic [1:0]  monMode,
  input  logic [2:0]  thrSel,
  input  logic        statusClr,
  input  logic        mainGood,
  input  logic        cmpBrownOut,
  input  logic        cmpError,
  input  logic        cmpWarn,
  output logic        cmpEnable,
  output logic [2:0]  thrCode,
  output logic        cfgErr,
  output logic        onBattery,
  output logic        nErr,
  output logic        nWrn
);
  monStb_t stbBus;

  batMonCtrl #(.BASE_TICKS(BASE_TICKS), .SETTLE(SETTLE)) i_ctrl (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .monMode(monMode),
    .statusClr(statusClr), .mainGood(mainGood),
    .cmpEnable(cmpEnable), .onBattery(onBattery), .stb(stbBus)
  );

  batMonDatapath i_dp (
    .clk(clk), .rstN(rstN), .stb(stbBus), .thrSel(thrSel),
    .cmpBrownOut(cmpBrownOut), .cmpError(cmpError), .cmpWarn(cmpWarn),
    .thrCode(thrCode), .cfgErr(cfgErr), .nErr(nErr), .nWrn(nWrn)
  );
endmodule

// File: rtl/batMonSeqChk.sv
module batMonSeqChk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] monMode,
  input logic [2:0] thrSel,
  input logic       mainGood,
  input logic       cmpEnable,
  input logic       sampleStb,
  input logic       nErr,
  input logic       nWrn,
  input logic       onBattery,
  input logic       cfgErr,
  input logic [2:0] thrCode
);
  // R2: no pulse while supervision is off
  a_r2_no_pulse_off: assert property (@(posedge clk) disable iff (!rstN)
    (monMode == 2'b00) |=> !cmpEnable);

  // R3: pulse lasts one cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cmpEnable |=> !cmpEnable);

  // R4: flags move only on a capture edge
  a_r4_err_on_sample: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(nErr) |-> $past(sampleStb));
  a_r4_wrn_on_sample: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(nWrn) |-> $past(sampleStb));

  // R7: reserved threshold codes
  a_r7_reserved_thr: assert property (@(posedge clk) disable iff (!rstN)
    (thrSel > 3'd4) |=> (cfgErr && thrCode == 3'd0));

  // R8: supply selection
  a_r8_main_sel: assert property (@(posedge clk) disable iff (!rstN)
    mainGood |=> !onBattery);
  a_r8_bat_sel: assert property (@(posedge clk) disable iff (!rstN)
    !mainGood |=> onBattery);
endmodule

bind batMonSeq batMonSeqChk u_chk (
  .clk(clk), .rstN(rstN), .monMode(monMode), .thrSel(thrSel),
  .mainGood(mainGood), .cmpEnable(cmpEnable), .sampleStb(stbBus.sample),
  .nErr(nErr), .nWrn(nWrn), .onBattery(onBattery), .cfgErr(cfgErr),
  .thrCode(thrCode)
);

// File: tb/test_batMonSeq.sv
module test_batMonSeq;
  localparam int BASE   = 4096;
  localparam int SETTLE = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] rateSel = 3'd4;
  logic [1:0] monMode = 2'b01;
  logic [2:0] thrSel = 3'd0;
  logic statusClr = 1'b0, mainGood = 1'b1;
  logic cmpBrownOut = 1'b0, cmpError = 1'b0, cmpWarn = 1'b0;
  logic cmpEnable, cfgErr, onBattery, nErr, nWrn;
  logic [2:0] thrCode;

  int tests = 0, fails = 0, cycle = 0, lastPulse = -1;
  int expQ[$];
  bit done = 1'b0;

  always #10 clk = ~clk;

  batMonSeq #(.BASE_TICKS(BASE), .SETTLE(SETTLE)) i_batMonSeq (
    .clk(clk), .rstN(rstN), .rateSel(rateSel), .monMode(monMode), .thrSel(thrSel),
    .statusClr(statusClr), .mainGood(mainGood), .cmpBrownOut(cmpBrownOut),
    .cmpError(cmpError), .cmpWarn(cmpWarn), .cmpEnable(cmpEnable),
    .thrCode(thrCode), .cfgErr(cfgErr), .onBattery(onBattery),
    .nErr(nErr), .nWrn(nWrn)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int expPeriod(input int code);
    int p;
    if (code == 7) return SETTLE + 1;
    p = BASE;
    for (int k = 0; k < code; k++) p = p / 4;
    return (p < SETTLE + 1) ? SETTLE + 1 : p;
  endfunction

  always @(posedge clk) cycle++;

  // Monitor: pops one expected interval per observed pulse (0 = ignore)
  always @(negedge clk) begin
    if (rstN && cmpEnable) begin
      if (lastPulse >= 0 && expQ.size() > 0) begin
        int e;
        e = expQ.pop_front();
        if (e > 0) chk((cycle - lastPulse) == e, "R1 period", cycle - lastPulse, e);
      end
      lastPulse = cycle;
    end
  end

  // Driver: select a rate, then queue the intervals it should produce
  task automatic drivePeriods(input int code, input int n);
    @(negedge clk);
    rateSel = 3'(code);
    @(posedge cmpEnable);
    expQ.push_back(0);
    for (int i = 0; i < n; i++) expQ.push_back(expPeriod(code));
    while (expQ.size() != 0) @(negedge clk);
  endtask

  task automatic clearStrobe();
    @(negedge clk); statusClr = 1'b1;
    @(negedge clk); statusClr = 1'b0;
  endtask

  task automatic warnWindow(input int offs);
    @(posedge cmpEnable);
    repeat (offs) @(negedge clk);
    cmpWarn = 1'b1;
    @(negedge clk);
    cmpWarn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    chk(cmpEnable == 0, "R9 reset pulse", cmpEnable, 0);
    chk(nErr == 1 && nWrn == 1, "R9 reset status", {nErr, nWrn}, 3);
    chk(cfgErr == 0, "R9 reset cfgErr", cfgErr, 0);
    chk(onBattery == 1, "R8 reset supply", onBattery, 1);
    rstN = 1'b1;
    @(negedge clk);
    chk(cmpEnable == 1, "R3 first pulse", cmpEnable, 1);
    chk(onBattery == 0, "R8 main supply", onBattery, 0);
    @(negedge clk);
    chk(cmpEnable == 0, "R3 pulse width", cmpEnable, 0);

    // R1 every rate code
    drivePeriods(4, 2); drivePeriods(5, 2); drivePeriods(6, 2); drivePeriods(7, 3);
    drivePeriods(3, 2); drivePeriods(2, 2); drivePeriods(1, 2); drivePeriods(0, 1);

    // R4 capture edge
    @(negedge clk); rateSel = 3'd4;
    @(posedge cmpEnable);
    warnWindow(SETTLE - 1);
    repeat (20) @(negedge clk);
    chk(nWrn == 1, "R4 early window ignored", nWrn, 1);
    warnWindow(SETTLE);
    repeat (2) @(negedge clk);
    chk(nWrn == 0, "R4 exact window captured", nWrn, 0);

    // R6 sticky, then clear
    repeat (40) @(negedge clk);
    chk(nWrn == 0, "R6 warning sticky", nWrn, 0);
    clearStrobe();
    repeat (40) @(negedge clk);
    chk(nWrn == 1, "R6 warning cleared", nWrn, 1);

    // R5 error level, warning independent
    cmpError = 1'b1;
    repeat (40) @(negedge clk);
    chk(nErr == 0, "R5 error flag", nErr, 0);
    chk(nWrn == 1, "R5 warning untouched", nWrn, 1);
    clearStrobe();
    repeat (40) @(negedge clk);
    chk(nErr == 0, "R6 clear refused while present", nErr, 0);
    cmpError = 1'b0; cmpBrownOut = 1'b1;
    clearStrobe();
    repeat (40) @(negedge clk);
    chk(nErr == 0, "R5 brown-out sets error", nErr, 0);
    cmpBrownOut = 1'b0;
    clearStrobe();
    repeat (40) @(negedge clk);
    chk(nErr == 1, "R6 error cleared", nErr, 1);

    // R2 supervision off
    @(negedge clk); monMode = 2'b00; cmpWarn = 1'b1;
    cnt = 0;
    repeat (100) begin @(negedge clk); if (cmpEnable) cnt++; end
    chk(cnt == 0, "R2 no pulses when off", cnt, 0);
    chk(nWrn == 1, "R2 flags frozen when off", nWrn, 1);
    monMode = 2'b10;
    @(negedge clk);
    chk(cmpEnable == 1, "R3 pulse on enable", cmpEnable, 1);
    repeat (40) @(negedge clk);
    chk(nWrn == 0, "R2 mode 10 enables", nWrn, 0);
    cmpWarn = 1'b0;

    // R7 threshold mapping
    thrSel = 3'd3; @(negedge clk);
    chk(thrCode == 3 && cfgErr == 0, "R7 valid code", {cfgErr, thrCode}, 3);
    thrSel = 3'd6; @(negedge clk);
    chk(thrCode == 0 && cfgErr == 1, "R7 reserved code", {cfgErr, thrCode}, 8);
    thrSel = 3'd4; @(negedge clk);
    chk(thrCode == 4 && cfgErr == 0, "R7 top valid code", {cfgErr, thrCode}, 4);

    // R8 supply switch
    mainGood = 1'b0; @(negedge clk);
    chk(onBattery == 1, "R8 to battery", onBattery, 1);
    mainGood = 1'b1; @(negedge clk);
    chk(onBattery == 0, "R8 back to main", onBattery, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule